// File: doc/BRIEF.md
# Serial Configuration Sequencer

This block loads a bitstream into a target FPGA through its slave-serial port. One strobe on `start_i` begins a session. The block pulls the target's clear line low and waits for the target's ready line to drop. It then releases the clear line and waits for the ready line to come back. Next it clocks out a fixed 16-bit sync word, followed by the payload bits. An upstream source supplies the payload one bit per ready/valid handshake, and a last flag marks the final bit. Once the final bit has gone out, the block waits for the target's up line to rise.

Each of the three waits has its own timeout and its own error code. The wait watches its input on every system clock and is measured in ticks of `TICK_CYCLES` clocks. A wait is abandoned when the number of elapsed ticks exceeds `MAX_POLLS` by two. Each serial bit is sent as four pin steps, and each step lasts `STEP_CYCLES` clocks. At the end of a session the block shows either success or an error code, and that result holds until the next start.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, the clear, serial clock and serial data outputs are all high. `busy_o`, `done_ok_o`, `err_o` and `bit_ready_o` are all 0.
- R2: A start seen while idle does three things from the next cycle: it drives `tgt_clr_n_o` low, raises `busy_o`, and keeps clock and data high. A start seen while busy has no effect.
- R3: In the first wait, `tgt_rdy_i` is sampled low to end the wait. If it is not seen low within LIM = (MAX_POLLS+2)*TICK_CYCLES clocks of the start edge, the session ends with `err_o` = 1 and all pins high.
- R4: Once `tgt_rdy_i` is seen low, `tgt_clr_n_o` returns high and the block waits for `tgt_rdy_i` high. If that is not seen within LIM clocks, the session ends with `err_o` = 2.
- R5: Each bit b is sent as four steps of STEP_CYCLES clocks each, given as {sclk,sdo}: {0,1}, {0,b}, {1,b}, {1,1}. Between bits, and outside shifting, both lines sit high.
- R6: Before any payload bit, the sync word 0xFF20 is sent most significant bit first.
- R7: `bit_ready_o` is high only while shifting, after the sync word, when the bit engine is free and the last bit has not yet been taken. Accepted bits are sent in order of acceptance, with no idle clocks when `bit_valid_i` stays high.
- R8: When the last bit's fourth step ends, the block waits for `tgt_up_i` high. Seeing it ends the session with `done_ok_o` = 1. If it is not seen within LIM clocks, the session ends with `err_o` = 3.
- R9: `err_o` and `done_ok_o` hold their values while idle and clear on the next accepted start. They are never both set.
- R10: A wait condition first seen on the very clock where the timeout would fire counts as met, and no error results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start strobe |
| tgt_rdy_i | input | 1 | Target ready line (low while the target clears) |
| tgt_up_i | input | 1 | Target configured line |
| bit_valid_i | input | 1 | Payload bit valid |
| bit_data_i | input | 1 | Payload bit value |
| bit_last_i | input | 1 | Marks the final payload bit |
| bit_ready_o | output | 1 | Payload bit accepted when high with valid |
| tgt_clr_n_o | output | 1 | Target clear request, active low |
| tgt_sclk_o | output | 1 | Serial configuration clock |
| tgt_sdo_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Session in progress |
| done_ok_o | output | 1 | Last session succeeded |
| err_o | output | 2 | 0 none, 1 ready stuck high, 2 ready stuck low, 3 no up |

## Verification
The bench runs several kinds of session: a clean one with a continuous payload, one where the ready line never drops, one where it never returns, and one with bubbled valid and no completion. Each of these separates one error path from the others. A boundary session meets each wait on exactly the LIM-th clock, which shows whether the timeout or the condition wins on that clock. A stray start in the middle of shifting shows whether a busy block ignores it. The captured serial stream is compared against the sync word plus payload, and this exposes ordering, dropped bits or duplicated bits.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_LO, ST_WAIT_HI, ST_SHIFT, ST_WAIT_UP
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_RDY_HIGH  = 2'd1,
    ERR_RDY_LOW   = 2'd2,
    ERR_NO_UP     = 2'd3
  } seq_err_t;

  // clocks allowed for one wait: the tick count must pass the poll limit
  function automatic int unsigned wait_limit(input int unsigned tick_cycles,
                                             input int unsigned max_polls);
    return (max_polls + 2) * tick_cycles;
  endfunction

  // {sclk, sdo} for step 0..3 of a bit
  function automatic logic [1:0] pin_pattern(input logic [1:0] step, input logic b);
    case (step)
      2'd0:    return 2'b01;
      2'd1:    return {1'b0, b};
      2'd2:    return {1'b1, b};
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/scl_wait_timer.sv
`timescale 1ns/1ps
module scl_wait_timer #(
  parameter int unsigned TICK_CYCLES = 125000,
  parameter int unsigned MAX_POLLS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic expire
);
  localparam int unsigned SUB_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int unsigned PC_W  = $clog2(MAX_POLLS + 3);

  logic [SUB_W-1:0] sub_q;
  logic [PC_W-1:0]  polls_q;
  logic             tick_end;

  assign tick_end = (sub_q == SUB_W'(TICK_CYCLES - 1));
  assign expire   = run && !clear && tick_end && (polls_q == PC_W'(MAX_POLLS + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      polls_q <= '0;
    end else if (clear || !run) begin
      sub_q   <= '0;
      polls_q <= '0;
    end else if (tick_end) begin
      sub_q   <= '0;
      polls_q <= polls_q + 1'b1;
    end else begin
      sub_q   <= sub_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_bit_stepper.sv
`timescale 1ns/1ps
module scl_bit_stepper
  import scl_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_bit,
  output logic free,
  output logic sclk,
  output logic sdo
);
  localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic             active_q;
  logic [1:0]       step_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bit_q;
  logic             step_end;

  assign step_end = (cnt_q == CNT_W'(STEP_CYCLES - 1));
  assign free     = !active_q || (step_q == 2'd3 && step_end);
  assign {sclk, sdo} = active_q ? pin_pattern(step_q, bit_q) : 2'b11;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= 2'd0;
      cnt_q    <= '0;
      bit_q    <= 1'b1;
    end else if (load) begin
      active_q <= 1'b1;
      step_q   <= 2'd0;
      cnt_q    <= '0;
      bit_q    <= load_bit;
    end else if (active_q) begin
      if (step_end) begin
        cnt_q <= '0;
        if (step_q == 2'd3) active_q <= 1'b0;
        else                step_q   <= step_q + 2'd1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_ctrl.sv
`timescale 1ns/1ps
module scl_ctrl
  import scl_pkg::*;
#(
  parameter int unsigned          HDR_BITS = 16,
  parameter logic [HDR_BITS-1:0]  HDR_WORD = 16'hFF20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tgt_rdy,
  input  logic       tgt_up,
  input  logic       bit_valid,
  input  logic       bit_data,
  input  logic       bit_last,
  input  logic       bit_free,
  input  logic       wait_expire,
  output logic       wait_run,
  output logic       wait_clear,
  output logic       load,
  output logic       load_bit,
  output logic       bit_ready,
  output logic       clr_n,
  output logic       busy,
  output logic       done_ok,
  output logic [1:0] err
);
  localparam int unsigned HC_W = $clog2(HDR_BITS + 1);

  seq_state_t          st_q;
  seq_err_t            err_q;
  logic                ok_q;
  logic [HC_W-1:0]     hdr_cnt_q;
  logic [HDR_BITS-1:0] hdr_sr_q;
  logic                last_taken_q;

  logic in_wait, cond_met, hdr_pending, take, shift_end;

  always_comb begin
    in_wait     = (st_q == ST_WAIT_LO) || (st_q == ST_WAIT_HI) || (st_q == ST_WAIT_UP);
    cond_met    = ((st_q == ST_WAIT_LO) && !tgt_rdy) ||
                  ((st_q == ST_WAIT_HI) &&  tgt_rdy) ||
                  ((st_q == ST_WAIT_UP) &&  tgt_up);
    hdr_pending = (hdr_cnt_q != HC_W'(HDR_BITS));
    bit_ready   = (st_q == ST_SHIFT) && !hdr_pending && bit_free && !last_taken_q;
    take        = bit_ready && bit_valid;
    load        = ((st_q == ST_SHIFT) && bit_free && hdr_pending) || take;
    load_bit    = hdr_pending ? hdr_sr_q[HDR_BITS-1] : bit_data;
    shift_end   = (st_q == ST_SHIFT) && bit_free && last_taken_q;
  end

  assign wait_run   = in_wait;
  assign wait_clear = !in_wait || cond_met;
  assign clr_n      = (st_q != ST_WAIT_LO);
  assign busy       = (st_q != ST_IDLE);
  assign done_ok    = ok_q;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      err_q        <= ERR_NONE;
      ok_q         <= 1'b0;
      hdr_cnt_q    <= '0;
      hdr_sr_q     <= HDR_WORD;
      last_taken_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_WAIT_LO;
          err_q <= ERR_NONE;
          ok_q  <= 1'b0;
        end
        ST_WAIT_LO: begin
          if (cond_met)         st_q <= ST_WAIT_HI;
          else if (wait_expire) begin
            st_q  <= ST_IDLE;
            err_q <= ERR_RDY_HIGH;
          end
        end
        ST_WAIT_HI: begin
          if (cond_met) begin
            st_q         <= ST_SHIFT;
            hdr_cnt_q    <= '0;
            hdr_sr_q     <= HDR_WORD;
            last_taken_q <= 1'b0;
          end else if (wait_expire) begin
            st_q  <= ST_IDLE;
            err_q <= ERR_RDY_LOW;
          end
        end
        ST_SHIFT: begin
          if (shift_end) st_q <= ST_WAIT_UP;
          if (load && hdr_pending) begin
            hdr_cnt_q <= hdr_cnt_q + 1'b1;
            hdr_sr_q  <= hdr_sr_q << 1;
          end
          if (take && bit_last) last_taken_q <= 1'b1;
        end
        ST_WAIT_UP: begin
          if (cond_met) begin
            st_q <= ST_IDLE;
            ok_q <= 1'b1;
          end else if (wait_expire) begin
            st_q  <= ST_IDLE;
            err_q <= ERR_NO_UP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader #(
  parameter int unsigned          TICK_CYCLES = 125000,
  parameter int unsigned          STEP_CYCLES = 4,
  parameter int unsigned          MAX_POLLS   = 3,
  parameter int unsigned          HDR_BITS    = 16,
  parameter logic [HDR_BITS-1:0]  HDR_WORD    = 16'hFF20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tgt_rdy_i,
  input  logic       tgt_up_i,
  input  logic       bit_valid_i,
  input  logic       bit_data_i,
  input  logic       bit_last_i,
  output logic       bit_ready_o,
  output logic       tgt_clr_n_o,
  output logic       tgt_sclk_o,
  output logic       tgt_sdo_o,
  output logic       busy_o,
  output logic       done_ok_o,
  output logic [1:0] err_o
);
  // internal events, named for the checker
  logic wait_run, wait_clear, wait_expire;
  logic bit_free, bit_load, bit_load_val;

  scl_wait_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .MAX_POLLS  (MAX_POLLS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (wait_run),
    .clear (wait_clear),
    .expire(wait_expire)
  );

  scl_bit_stepper #(
    .STEP_CYCLES(STEP_CYCLES)
  ) u_stepper (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (bit_load),
    .load_bit(bit_load_val),
    .free    (bit_free),
    .sclk    (tgt_sclk_o),
    .sdo     (tgt_sdo_o)
  );

  scl_ctrl #(
    .HDR_BITS(HDR_BITS),
    .HDR_WORD(HDR_WORD)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .tgt_rdy    (tgt_rdy_i),
    .tgt_up     (tgt_up_i),
    .bit_valid  (bit_valid_i),
    .bit_data   (bit_data_i),
    .bit_last   (bit_last_i),
    .bit_free   (bit_free),
    .wait_expire(wait_expire),
    .wait_run   (wait_run),
    .wait_clear (wait_clear),
    .load       (bit_load),
    .load_bit   (bit_load_val),
    .bit_ready  (bit_ready_o),
    .clr_n      (tgt_clr_n_o),
    .busy       (busy_o),
    .done_ok    (done_ok_o),
    .err        (err_o)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
`timescale 1ns/1ps
module serial_cfg_loader_chk
  import scl_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 125000,
  parameter int unsigned MAX_POLLS   = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_up_i,
  input logic       bit_ready_o,
  input logic       tgt_clr_n_o,
  input logic       tgt_sclk_o,
  input logic       tgt_sdo_o,
  input logic       busy_o,
  input logic       done_ok_o,
  input logic [1:0] err_o,
  input logic       wait_expire,
  input logic       bit_load,
  input logic       bit_free
);
  localparam int unsigned LIM = wait_limit(TICK_CYCLES, MAX_POLLS);

  int unsigned lo_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lo_len <= 0;
    else if (!tgt_clr_n_o) lo_len <= lo_len + 1;
    else                  lo_len <= 0;
  end

  // R2
  clr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_clr_n_o |-> busy_o);

  // R3
  clr_low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_len <= LIM);

  // R3
  expire_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expire |-> (busy_o && tgt_sclk_o && tgt_sdo_o));

  // R5
  rise_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_sclk_o) |-> $stable(tgt_sdo_o));

  // R5
  fall_data_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_sclk_o) |-> tgt_sdo_o);

  // R5
  load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_load |-> bit_free);

  // R7
  ready_lines_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready_o |-> (busy_o && tgt_clr_n_o && tgt_sclk_o && tgt_sdo_o));

  // R8
  ok_follows_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok_o) |-> $past(tgt_up_i));

  // R9
  result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != 2'd0) |-> !done_ok_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> ($stable(err_o) && $stable(done_ok_o)));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
  .TICK_CYCLES(TICK_CYCLES),
  .MAX_POLLS  (MAX_POLLS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tgt_up_i   (tgt_up_i),
  .bit_ready_o(bit_ready_o),
  .tgt_clr_n_o(tgt_clr_n_o),
  .tgt_sclk_o (tgt_sclk_o),
  .tgt_sdo_o  (tgt_sdo_o),
  .busy_o     (busy_o),
  .done_ok_o  (done_ok_o),
  .err_o      (err_o),
  .wait_expire(wait_expire),
  .bit_load   (bit_load),
  .bit_free   (bit_free)
);

// File: tb/serial_cfg_loader_bench.sv
`timescale 1ns/1ps
module serial_cfg_loader_bench;
  localparam int TICK  = 6;
  localparam int STEP  = 2;
  localparam int POLLS = 3;
  localparam int LIM   = 5 * TICK;     // give up once more than POLLS+1 ticks have passed
  localparam int BLEN  = 4 * STEP;
  localparam int SYNC  = 'hFF20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, tgt_rdy_i = 1'b1, tgt_up_i = 1'b0;
  logic bit_valid_i = 1'b0, bit_data_i = 1'b0, bit_last_i = 1'b0;
  logic bit_ready_o, tgt_clr_n_o, tgt_sclk_o, tgt_sdo_o, busy_o, done_ok_o;
  logic [1:0] err_o;

  always #4 clk = ~clk;

  serial_cfg_loader #(
    .TICK_CYCLES(TICK), .STEP_CYCLES(STEP), .MAX_POLLS(POLLS),
    .HDR_BITS(16), .HDR_WORD(16'hFF20)
  ) u_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_rdy_i(tgt_rdy_i),
    .tgt_up_i(tgt_up_i), .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i),
    .bit_last_i(bit_last_i), .bit_ready_o(bit_ready_o), .tgt_clr_n_o(tgt_clr_n_o),
    .tgt_sclk_o(tgt_sclk_o), .tgt_sdo_o(tgt_sdo_o), .busy_o(busy_o),
    .done_ok_o(done_ok_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model: mode numbers are the bench's own ----------------
  int m_mode = 0;   // 0 idle, 1 clear low, 2 await ready, 3 shift, 4 await up
  int m_t = 0, m_hdr = 0, m_pos = -1, m_bit = 0, m_err = 0;
  bit m_ok = 0, m_lastseen = 0;
  bit m_fr, m_rd;

  function automatic bit m_free();
    return (m_pos < 0) || (m_pos == BLEN - 1);
  endfunction
  function automatic bit e_ready();
    return (m_mode == 3) && (m_hdr == 16) && m_free() && !m_lastseen;
  endfunction
  function automatic bit e_sclk();
    if (m_pos < 0) return 1'b1;
    return (m_pos / STEP) >= 2;
  endfunction
  function automatic bit e_sdo();
    int s;
    if (m_pos < 0) return 1'b1;
    s = m_pos / STEP;
    if (s == 0 || s == 3) return 1'b1;
    return m_bit[0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_hdr = 0; m_pos = -1; m_err = 0; m_ok = 0; m_lastseen = 0;
    end else begin
      m_fr = m_free();
      m_rd = e_ready();
      case (m_mode)
        0: if (start_i) begin m_mode = 1; m_t = 0; m_err = 0; m_ok = 0; end
        1: if (!tgt_rdy_i) begin m_mode = 2; m_t = 0; end
           else begin m_t++; if (m_t == LIM) begin m_mode = 0; m_err = 1; end end
        2: if (tgt_rdy_i) begin m_mode = 3; m_hdr = 0; m_pos = -1; m_lastseen = 0; end
           else begin m_t++; if (m_t == LIM) begin m_mode = 0; m_err = 2; end end
        3: begin
          if (m_pos >= 0) begin m_pos++; if (m_pos == BLEN) m_pos = -1; end
          if (m_fr) begin
            if (m_hdr < 16) begin
              m_bit = (SYNC >> (15 - m_hdr)) & 1; m_hdr++; m_pos = 0;
            end else if (m_lastseen) begin
              m_mode = 4; m_t = 0;
            end else if (m_rd && bit_valid_i) begin
              m_bit = int'(bit_data_i); m_lastseen = bit_last_i; m_pos = 0;
            end
          end
        end
        4: if (tgt_up_i) begin m_mode = 0; m_ok = 1; end
           else begin m_t++; if (m_t == LIM) begin m_mode = 0; m_err = 3; end end
        default: m_mode = 0;
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", "clr_n",   int'(tgt_clr_n_o), int'(m_mode != 1));
      check("R2", "busy",    int'(busy_o),      int'(m_mode != 0));
      check("R5", "sclk",    int'(tgt_sclk_o),  int'(e_sclk()));
      check("R5", "sdo",     int'(tgt_sdo_o),   int'(e_sdo()));
      check("R7", "ready",   int'(bit_ready_o), int'(e_ready()));
      check("R8", "done_ok", int'(done_ok_o),   int'(m_ok));
      check("R9", "err",     int'(err_o),       m_err);
    end
  end

  // serial stream capture on rising serial clock
  bit seen[$];
  bit prev_sclk = 1'b1;
  always @(negedge clk) begin
    if (!prev_sclk && tgt_sclk_o) seen.push_back(tgt_sdo_o);
    prev_sclk = tgt_sclk_o;
  end

  // payload source
  logic [1:0] src_q[$];   // {last, data}
  bit bubbles = 0;
  int src_cyc = 0;
  initial begin
    forever begin
      @(negedge clk);
      src_cyc++;
      if (src_q.size() > 0 && !(bubbles && (src_cyc % 3 == 0))) begin
        bit_valid_i = 1'b1; bit_data_i = src_q[0][0]; bit_last_i = src_q[0][1];
      end else begin
        bit_valid_i = 1'b0; bit_data_i = 1'b0; bit_last_i = 1'b0;
      end
      #1;
      if (bit_valid_i && bit_ready_o) void'(src_q.pop_front());
    end
  end

  bit exp_stream[$];
  task automatic prep(input logic [31:0] bits, input int n);
    seen.delete(); exp_stream.delete(); src_q.delete();
    for (int i = 15; i >= 0; i--) exp_stream.push_back(SYNC[i]);
    for (int i = n - 1; i >= 0; i--) begin
      src_q.push_back({(i == 0), bits[i]});
      exp_stream.push_back(bits[i]);
    end
  endtask

  task automatic stream_check(input string req, input bit payload_sent);
    int n = payload_sent ? exp_stream.size() : 16;
    check(req, "stream length", seen.size(), n);
    for (int i = 0; i < n && i < seen.size(); i++)
      check(i < 16 ? "R6" : "R7", $sformatf("stream bit %0d", i), int'(seen[i]), int'(exp_stream[i]));
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy_o && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset clr_n", int'(tgt_clr_n_o), 1);
    check("R1", "reset sclk",  int'(tgt_sclk_o), 1);
    check("R1", "reset sdo",   int'(tgt_sdo_o), 1);
    check("R1", "reset busy",  int'(busy_o), 0);
    check("R1", "reset ok/err/ready", {done_ok_o, err_o, bit_ready_o}, 0);

    // A: clean session, continuous payload, stray start during shift
    prep(32'b11_0100_1110, 10);
    do_start();
    check("R2", "clear low after start", int'(tgt_clr_n_o), 0);
    check("R2", "busy after start", int'(busy_o), 1);
    repeat (3) @(negedge clk); tgt_rdy_i = 1'b0;
    repeat (4) @(negedge clk); tgt_rdy_i = 1'b1;
    repeat (12) @(negedge clk);
    do_start();   // ignored while busy (R2)
    n = 0;
    while (seen.size() < 26 && n < 2000) begin @(negedge clk); n++; end
    repeat (BLEN + 3) @(negedge clk);
    check("R8", "still busy awaiting up", int'(busy_o), 1);
    tgt_up_i = 1'b1;
    wait_idle();
    tgt_up_i = 1'b0;
    check("R8", "session A ok", int'(done_ok_o), 1);
    check("R2", "stray start ignored, err", int'(err_o), 0);
    stream_check("R7", 1);

    // B: ready never drops
    prep(32'b1, 1);
    do_start();
    n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    check("R3", "clocks until timeout", n, LIM);
    check("R3", "error code", int'(err_o), 1);
    check("R3", "clear released", int'(tgt_clr_n_o), 1);
    repeat (20) @(negedge clk);
    check("R9", "error held while idle", int'(err_o), 1);

    // C: ready drops and never returns
    do_start();
    check("R9", "error cleared by start", int'(err_o), 0);
    repeat (2) @(negedge clk); tgt_rdy_i = 1'b0;
    wait_idle();
    check("R4", "error code", int'(err_o), 2);
    tgt_rdy_i = 1'b1;

    // D: bubbled payload, target never comes up
    prep(32'b10110, 5);
    bubbles = 1;
    do_start();
    @(negedge clk); tgt_rdy_i = 1'b0;
    @(negedge clk); tgt_rdy_i = 1'b1;
    wait_idle();
    bubbles = 0;
    check("R8", "up timeout code", int'(err_o), 3);
    check("R9", "no success with error", int'(done_ok_o), 0);
    stream_check("R7", 1);

    // E: each wait met on its last allowed clock
    prep(32'b011, 3);
    do_start();
    repeat (LIM - 1) @(negedge clk); tgt_rdy_i = 1'b0;
    @(negedge clk);
    check("R10", "first wait met at limit, busy", int'(busy_o), 1);
    check("R10", "first wait met at limit, clear high", int'(tgt_clr_n_o), 1);
    repeat (LIM - 2) @(negedge clk); tgt_rdy_i = 1'b1;
    @(negedge clk);
    check("R10", "second wait met at limit, busy", int'(busy_o), 1);
    check("R10", "second wait met at limit, err", int'(err_o), 0);
    tgt_up_i = 1'b1;
    wait_idle();
    tgt_up_i = 1'b0;
    check("R10", "boundary session ok", int'(done_ok_o), 1);
    stream_check("R6", 1);
    repeat (5) @(negedge clk);
    check("R9", "success held", int'(done_ok_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule